// File: doc/BRIEF.md
# Configuration Access Port Bridge

This block sits on the host side of a peripheral bus. It turns processor I/O accesses to two fixed port addresses into bus configuration cycles. Software first writes a 32-bit selector word to the address port at 0x0CF8. That word holds an enable flag, a function number and a doubleword index. A later access to the data port at 0x0CFC then launches one configuration cycle. Its address word is packed from the stored selector.

A data-port read launches a configuration-read cycle and hands the returned word back to the processor. A data-port write launches a configuration-write cycle and forwards the processor's data unchanged. When the enable flag is clear, no cycle is issued. Every access the block accepts ends with a one-cycle done pulse. The processor waits for that pulse before it issues its next access.

Top module: `cfg_port_bridge`

## Requirements
- R1: A write to port 0x0CF8 stores all 32 data bits. A later read of 0x0CF8 returns the stored word unchanged. Both accesses raise `io_done` in the cycle after the request edge.
- R2: With bit 31 of the stored word set, a data-port (0x0CFC) access issues exactly one bus cycle. A read uses command 4'b1010 and a write uses command 4'b1011.
- R3: The cycle's address word takes bits [10:8] (function number) and bits [7:2] (doubleword index) from the same positions of the stored word. Bits [1:0] and bits [31:11] are 0.
- R4: With bit 31 of the stored word clear, a data-port access issues no bus cycle. A read returns 32'hFFFF_FFFF, a write is dropped, and the access still completes with `io_done`.
- R5: `io_done` is a single-cycle pulse. After a bus cycle, it rises in the cycle after the edge that samples `cyc_valid` and `cyc_ack` both high. On a read, `io_rdata` then holds the `cyc_rdata` value sampled at that edge.
- R6: On a configuration write, `cyc_wdata` equals the processor's write data and stays constant while `cyc_valid` is high.
- R7: Once raised, `cyc_valid` stays high, with `cyc_cmd` and `cyc_ad` constant, until the edge at which `cyc_ack` is sampled high. It is low in the following cycle.
- R8: A request to any port other than 0x0CF8 and 0x0CFC produces no `io_done` and no bus cycle, and leaves the stored word unchanged.
- R9: Reset clears the stored word to 0 and drives `cyc_valid` and `io_done` low, including when reset arrives during an open bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | One-cycle processor I/O request |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 32 | Processor write data |
| io_rdata | output | 32 | Read data, valid while io_done is high |
| io_done | output | 1 | One-cycle completion pulse |
| cyc_valid | output | 1 | Configuration cycle in progress |
| cyc_cmd | output | 4 | Bus command for the cycle |
| cyc_ad | output | 32 | Packed address word for the cycle |
| cyc_wdata | output | 32 | Write data for a configuration write |
| cyc_ack | input | 1 | Bus completion of the current cycle |
| cyc_rdata | input | 32 | Data returned by a configuration read |

## Verification
The assertions assume the processor never raises `io_req` while a bus cycle is open or while `io_done` is high. The bench follows that rule: each access drives a single request cycle, then waits for the done pulse, or for a fixed window on ignored ports, before issuing the next. The bench's bus responder raises `cyc_ack` for exactly one cycle, after a latency of one to three cycles set per vector, so the cycle-hold properties see both short and stretched cycles.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } seq_st_e;

endpackage

// File: rtl/cfgb_port_decode.sv
module cfgb_port_decode #(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
    input  logic             io_req,
    input  logic [IO_AW-1:0] io_addr,
    output logic             hit_addr,
    output logic             hit_data
);
    localparam logic [IO_AW-1:0] SEL_PORT = ADDR_PORT[IO_AW-1:0];
    localparam logic [IO_AW-1:0] DAT_PORT = DATA_PORT[IO_AW-1:0];

    always_comb begin
        hit_addr = io_req && (io_addr == SEL_PORT);
        hit_data = io_req && (io_addr == DAT_PORT);
    end
endmodule

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    logic [DW-1:0] sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (we) sel_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign q = sel_q;
endmodule

// File: rtl/cfgb_ad_pack.sv
module cfgb_ad_pack #(
    parameter int DW    = 32,
    parameter int IDX_W = 6,
    parameter int FN_W  = 3
) (
    input  logic [DW-1:0] sel,
    output logic [DW-1:0] ad,
    output logic          enabled
);
    localparam int IDX_LO = 2;
    localparam int FLD_HI = IDX_LO + IDX_W + FN_W - 1;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b >= IDX_LO && b <= FLD_HI) begin : g_keep
            assign ad[b] = sel[b];
        end else begin : g_zero
            assign ad[b] = 1'b0;
        end
    end

    assign enabled = sel[DW-1];
endmodule

// File: rtl/cfgb_cycle_seq.sv
module cfgb_cycle_seq
    import cfgb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_addr,
    input  logic          hit_data,
    input  logic          io_wr,
    input  logic [DW-1:0] io_wdata,
    input  logic [DW-1:0] sel_word,
    input  logic [DW-1:0] ad_packed,
    input  logic          cfg_en,
    input  logic          cyc_ack,
    input  logic [DW-1:0] cyc_rdata,
    output logic          sel_we,
    output logic          cyc_valid,
    output logic [3:0]    cyc_cmd,
    output logic [DW-1:0] cyc_ad,
    output logic [DW-1:0] cyc_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          io_done
);
    typedef struct packed {
        seq_st_e       st;
        logic          valid;
        logic [3:0]    cmd;
        logic [DW-1:0] ad;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;
    logic idle;

    assign idle   = (s_q.st == ST_IDLE);
    assign sel_we = idle && hit_addr && io_wr;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (hit_addr) begin
                    s_d.done = 1'b1;
                    if (!io_wr) s_d.rdata = sel_word;
                end else if (hit_data) begin
                    if (cfg_en) begin
                        s_d.st    = ST_BUS;
                        s_d.valid = 1'b1;
                        s_d.cmd   = io_wr ? CMD_CFG_WR : CMD_CFG_RD;
                        s_d.ad    = ad_packed;
                        s_d.wdata = io_wr ? io_wdata : '0;
                    end else begin
                        s_d.done = 1'b1;
                        if (!io_wr) s_d.rdata = '1;
                    end
                end
            end
            ST_BUS: begin
                if (cyc_ack) begin
                    s_d.st    = ST_IDLE;
                    s_d.valid = 1'b0;
                    s_d.done  = 1'b1;
                    if (s_q.cmd == CMD_CFG_RD) s_d.rdata = cyc_rdata;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.valid <= 1'b0;
            s_q.cmd   <= '0;
            s_q.ad    <= '0;
            s_q.wdata <= '0;
            s_q.rdata <= '0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cyc_valid = s_q.valid;
    assign cyc_cmd   = s_q.cmd;
    assign cyc_ad    = s_q.ad;
    assign cyc_wdata = s_q.wdata;
    assign io_rdata  = s_q.rdata;
    assign io_done   = s_q.done;
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
    parameter int          IO_AW     = 16,
    parameter int          DW        = 32,
    parameter int          IDX_W     = 6,
    parameter int          FN_W      = 3,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [DW-1:0]    io_wdata,
    output logic [DW-1:0]    io_rdata,
    output logic             io_done,
    output logic             cyc_valid,
    output logic [3:0]       cyc_cmd,
    output logic [DW-1:0]    cyc_ad,
    output logic [DW-1:0]    cyc_wdata,
    input  logic             cyc_ack,
    input  logic [DW-1:0]    cyc_rdata
);
    logic          hit_addr, hit_data, sel_we, cfg_en;
    logic [DW-1:0] sel_word, ad_packed;

    cfgb_port_decode #(
        .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
    ) u_decode (
        .io_req(io_req), .io_addr(io_addr),
        .hit_addr(hit_addr), .hit_data(hit_data)
    );

    cfgb_addr_reg #(.DW(DW)) u_sel (
        .clk(clk), .rst_n(rst_n), .we(sel_we), .wdata(io_wdata), .q(sel_word)
    );

    cfgb_ad_pack #(.DW(DW), .IDX_W(IDX_W), .FN_W(FN_W)) u_pack (
        .sel(sel_word), .ad(ad_packed), .enabled(cfg_en)
    );

    cfgb_cycle_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .hit_addr(hit_addr), .hit_data(hit_data),
        .io_wr(io_wr), .io_wdata(io_wdata),
        .sel_word(sel_word), .ad_packed(ad_packed), .cfg_en(cfg_en),
        .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata),
        .sel_we(sel_we),
        .cyc_valid(cyc_valid), .cyc_cmd(cyc_cmd), .cyc_ad(cyc_ad),
        .cyc_wdata(cyc_wdata), .io_rdata(io_rdata), .io_done(io_done)
    );
endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          io_req,
    input logic          io_done,
    input logic          cyc_valid,
    input logic [3:0]    cyc_cmd,
    input logic [DW-1:0] cyc_ad,
    input logic [DW-1:0] cyc_wdata,
    input logic          cyc_ack
);
    // input rule: no request while a cycle is open or done is showing
    io_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid || io_done) |-> !io_req);

    // R2
    cyc_cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_cmd == 4'b1010 || cyc_cmd == 4'b1011));

    // R3
    ad_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_ad[1:0] == 2'b00 && cyc_ad[DW-1:11] == '0));

    // R5
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_ack) |=> io_done);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_done |=> !io_done);

    // R6
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_ack) |=> $stable(cyc_wdata));

    // R7
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_ack) |=> (cyc_valid && $stable(cyc_cmd) && $stable(cyc_ad)));

    // R7
    cyc_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_ack) |=> !cyc_valid);
endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_done(io_done),
    .cyc_valid(cyc_valid), .cyc_cmd(cyc_cmd), .cyc_ad(cyc_ad),
    .cyc_wdata(cyc_wdata), .cyc_ack(cyc_ack)
);

// File: tb/cfg_port_bridge_test.sv
module cfg_port_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0, io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [31:0] io_wdata = '0, io_rdata, cyc_ad, cyc_wdata;
    logic [31:0] cyc_rdata = '0;
    logic        io_done, cyc_valid, cyc_ack = 1'b0;
    logic [3:0]  cyc_cmd;

    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    cfg_port_bridge uut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_done(io_done), .cyc_valid(cyc_valid), .cyc_cmd(cyc_cmd),
        .cyc_ad(cyc_ad), .cyc_wdata(cyc_wdata), .cyc_ack(cyc_ack),
        .cyc_rdata(cyc_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [31:0] bus_rd;
        logic [3:0]  lat;
        logic        e_done;
        logic        e_cyc;
        logic [3:0]  e_cmd;
        logic [31:0] e_ad;
        logic [31:0] e_rd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h0CFC, 32'h0,         32'h0,         4'd1, 1'b1, 1'b0, 4'h0, 32'h0,   32'hFFFF_FFFF},
        '{1'b1, 16'h0CF8, 32'h8000_0A3C, 32'h0,         4'd1, 1'b1, 1'b0, 4'h0, 32'h0,   32'h0},
        '{1'b0, 16'h0CF8, 32'h0,         32'h0,         4'd1, 1'b1, 1'b0, 4'h0, 32'h0,   32'h8000_0A3C},
        '{1'b0, 16'h0CFC, 32'h0,         32'h1234_5678, 4'd1, 1'b1, 1'b1, 4'hA, 32'h23C, 32'h1234_5678},
        '{1'b1, 16'h0CFC, 32'hDEAD_BEEF, 32'h0,         4'd3, 1'b1, 1'b1, 4'hB, 32'h23C, 32'h0},
        '{1'b1, 16'h0CF8, 32'hFFFF_FFFF, 32'h0,         4'd1, 1'b1, 1'b0, 4'h0, 32'h0,   32'h0},
        '{1'b0, 16'h0CFC, 32'h0,         32'hCAFE_F00D, 4'd2, 1'b1, 1'b1, 4'hA, 32'h7FC, 32'hCAFE_F00D},
        '{1'b1, 16'h0CF9, 32'h1111_1111, 32'h0,         4'd1, 1'b0, 1'b0, 4'h0, 32'h0,   32'h0},
        '{1'b0, 16'h0CF8, 32'h0,         32'h0,         4'd1, 1'b1, 1'b0, 4'h0, 32'h0,   32'hFFFF_FFFF},
        '{1'b1, 16'h0CF8, 32'h0000_0104, 32'h0,         4'd1, 1'b1, 1'b0, 4'h0, 32'h0,   32'h0},
        '{1'b1, 16'h0CFC, 32'h5555_AAAA, 32'h0,         4'd1, 1'b1, 1'b0, 4'h0, 32'h0,   32'h0},
        '{1'b0, 16'h0CFC, 32'h0,         32'h7777_7777, 4'd1, 1'b1, 1'b0, 4'h0, 32'h0,   32'hFFFF_FFFF},
        '{1'b0, 16'h1CF8, 32'h0,         32'h0,         4'd1, 1'b0, 1'b0, 4'h0, 32'h0,   32'h0},
        '{1'b0, 16'h0CF8, 32'h0,         32'h0,         4'd1, 1'b1, 1'b0, 4'h0, 32'h0,   32'h0000_0104}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        bit          saw = 0, got = 0, stable_ok = 1;
        int          cnt = 0;
        logic [3:0]  cmd = '0;
        logic [31:0] ad = '0, wd = '0, rd = '0;
        @(negedge clk);
        io_req = 1'b1; io_wr = v.wr; io_addr = v.addr; io_wdata = v.wdata;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            io_req = 1'b0;
            cyc_ack = 1'b0;
            if (io_done) begin
                got = 1; rd = io_rdata;
                break;
            end
            if (cyc_valid) begin
                if (!saw) begin
                    saw = 1; cmd = cyc_cmd; ad = cyc_ad; wd = cyc_wdata;
                end else if (cyc_cmd != cmd || cyc_ad != ad || cyc_wdata != wd) begin
                    stable_ok = 0;
                end
                cnt++;
                if (cnt == int'(v.lat)) begin
                    cyc_ack = 1'b1; cyc_rdata = v.bus_rd;
                end
            end
        end
        chk(got == v.e_done, "R5 R8 done", 32'(got), 32'(v.e_done));
        chk(saw == v.e_cyc, "R2 R4 R8 cycle issued", 32'(saw), 32'(v.e_cyc));
        if (v.e_cyc) begin
            chk(cmd == v.e_cmd, "R2 command", 32'(cmd), 32'(v.e_cmd));
            chk(ad == v.e_ad, "R3 ad packing", ad, v.e_ad);
            chk(stable_ok, "R7 hold", 32'(stable_ok), 32'd1);
            if (v.wr) chk(wd == v.wdata, "R6 write data", wd, v.wdata);
        end
        if (got && !v.wr) chk(rd == v.e_rd, "R1 R4 R5 read data", rd, v.e_rd);
        if (got) begin
            @(negedge clk);
            chk(!io_done, "R5 single pulse", 32'(io_done), 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!io_done && !cyc_valid, "R9 reset outputs", {30'd0, io_done, cyc_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R9: reset during an open bus cycle
        run_vec('{1'b1, 16'h0CF8, 32'h8000_0510, 32'h0, 4'd1, 1'b1, 1'b0, 4'h0, 32'h0, 32'h0});
        @(negedge clk);
        io_req = 1'b1; io_wr = 1'b0; io_addr = 16'h0CFC;
        @(negedge clk);
        io_req = 1'b0;
        chk(cyc_valid, "R2 cycle opened", 32'(cyc_valid), 32'd1);
        chk(cyc_ad == 32'h510, "R3 ad packing", cyc_ad, 32'h510);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!cyc_valid && !io_done, "R9 reset mid cycle", {30'd0, io_done, cyc_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_vec('{1'b0, 16'h0CF8, 32'h0, 32'h0, 4'd1, 1'b1, 1'b0, 4'h0, 32'h0, 32'h0});
        run_vec('{1'b0, 16'h0CFC, 32'h0, 32'h0, 4'd1, 1'b1, 1'b0, 4'h0, 32'h0, 32'hFFFF_FFFF});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule